// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block sits between a set of external interrupt request lines and a small processor core. Every line carries its own enable flag, pending flag, active flag and 4-bit urgency level. A single write port lets software change any of them. Each cycle the controller picks the most urgent line that is enabled, pending and not already being serviced. It offers that line's vector to the core only when the line is strictly more urgent than the handler now running. The core accepts the offer with an acknowledge pulse and later reports the end of the handler with a completion pulse.

The controller keeps a stack of the handlers that are in progress. Each stack entry holds the line index and the urgency the line had when it was taken. The top entry sets the running level. A completion pops that entry, clears the line's active flag and brings back the level of the handler that was preempted. With an empty stack the core runs background code at level 16, so any request can be offered. The offer is computed from the current state in every cycle. An urgent request that arrives just before the acknowledge therefore replaces a less urgent one that was on offer.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, no line is enabled, pending or active, every urgency level is 0, `irq_valid_o` is low and `run_level_o` reads 16 (idle).
- R2: A 0-to-1 transition on `irq_i[n]` sets pending for line n; a line held high sets it only once. A configuration write with `cfg_op` = 2 sets pending and `cfg_op` = 3 clears it, for line `cfg_line`.
- R3: `cfg_op` = 0 enables and `cfg_op` = 1 disables line `cfg_line`. A disabled line still latches pending but is never offered; enabling it later makes it eligible.
- R4: Among eligible lines (enabled, pending, not active) the smallest urgency value wins (0 most urgent, 15 least); on equal values the lower line index wins. `cfg_op` = 4 writes `cfg_data` as the urgency of line `cfg_line`.
- R5: `irq_vector_o` equals 16 plus the index of the winning line.
- R6: `irq_valid_o` is high only when the winner's urgency value is strictly smaller than `run_level_o`; an equal or larger value waits.
- R7: `irq_ack_i` while `irq_valid_o` is high clears the winner's pending flag, sets its active flag, pushes it on the stack and makes `run_level_o` the winner's urgency on the next cycle.
- R8: A line that is re-requested while active becomes active-and-pending. It is not offered until its own handler completes, and it is offered again afterwards.
- R9: `irq_done_i` clears the active flag of the top stack entry and restores `run_level_o` to the preempted handler's level, or to 16 when the stack empties. `irq_done_i` with an empty stack changes nothing.
- R10: `irq_ack_i` while `irq_valid_o` is low is ignored. When `irq_ack_i` and `irq_done_i` are high in the same cycle, only the completion takes effect.
- R11: Rewriting the urgency of an active line does not change the running level that was captured when the line was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | NUM_LINES | Request lines, rising-edge sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Write operation: 0 enable, 1 disable, 2 set pending, 3 clear pending, 4 write urgency |
| cfg_line | input | IDX_W | Line addressed by the write |
| cfg_data | input | PRIO_W | Urgency value for operation 4 |
| irq_ack_i | input | 1 | Core takes the offered vector |
| irq_done_i | input | 1 | Core finished the innermost handler |
| irq_valid_o | output | 1 | A request may preempt now |
| irq_vector_o | output | VEC_W | Vector number of the offered request |
| run_level_o | output | PRIO_W+1 | Urgency of running handler, 16 when idle |
| pend_o | output | NUM_LINES | Pending flag per line |
| act_o | output | NUM_LINES | Active flag per line |

## Verification
The bench aims at the tie between two lines of equal urgency. A design that compared with less-or-equal would offer the higher index. It checks that a request of the same urgency as the running handler waits; an off-by-one in the comparison would let a handler preempt itself or its peers. Re-requesting a line while it is active must leave the line pending but not offered, or it would nest on top of itself. A completion must restore the preempted level, not the idle level, or nested lines would be offered too early. The bench also applies acknowledge and completion in the same cycle, completion with an empty stack, and an urgency rewrite while the line is active. Each of these would corrupt the stack or the running level if handled wrong.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef enum logic [2:0] {
    CFG_ENABLE   = 3'd0,
    CFG_DISABLE  = 3'd1,
    CFG_SET_PEND = 3'd2,
    CFG_CLR_PEND = 3'd3,
    CFG_PRIO     = 3'd4
  } cfg_op_e;

  localparam int unsigned VEC_BASE = 16;
endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned PRIO_W    = 4,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LINES-1:0]          irq_i,
  input  logic                          cfg_we,
  input  logic [2:0]                    cfg_op,
  input  logic [IDX_W-1:0]              cfg_line,
  input  logic [PRIO_W-1:0]             cfg_data,
  input  logic                          take_en,
  input  logic [IDX_W-1:0]              take_idx,
  input  logic                          done_en,
  input  logic [IDX_W-1:0]              done_idx,
  output logic [NUM_LINES-1:0]          en_o,
  output logic [NUM_LINES-1:0]          pend_o,
  output logic [NUM_LINES-1:0]          act_o,
  output logic [NUM_LINES*PRIO_W-1:0]   prio_flat_o
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic              irq_q;
    logic              en_q, en_n;
    logic              pend_q, pend_n;
    logic              act_q, act_n;
    logic [PRIO_W-1:0] prio_q, prio_n;
    logic              sel, edge_hit, set_hit, clr_hit, take_hit, done_hit;

    always_comb begin
      sel      = cfg_we && (cfg_line == IDX_W'(g));
      edge_hit = irq_i[g] && !irq_q;
      set_hit  = sel && (cfg_op == CFG_SET_PEND);
      clr_hit  = sel && (cfg_op == CFG_CLR_PEND);
      take_hit = take_en && (take_idx == IDX_W'(g));
      done_hit = done_en && (done_idx == IDX_W'(g));

      en_n = en_q;
      if (sel && (cfg_op == CFG_ENABLE))  en_n = 1'b1;
      if (sel && (cfg_op == CFG_DISABLE)) en_n = 1'b0;

      prio_n = prio_q;
      if (sel && (cfg_op == CFG_PRIO)) prio_n = cfg_data;

      pend_n = (pend_q && !take_hit && !clr_hit) || edge_hit || set_hit;

      act_n = act_q;
      if (done_hit) act_n = 1'b0;
      if (take_hit) act_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_q  <= 1'b0;
        en_q   <= 1'b0;
        pend_q <= 1'b0;
        act_q  <= 1'b0;
        prio_q <= '0;
      end else begin
        irq_q  <= irq_i[g];
        en_q   <= en_n;
        pend_q <= pend_n;
        act_q  <= act_n;
        prio_q <= prio_n;
      end
    end

    assign en_o[g]                          = en_q;
    assign pend_o[g]                        = pend_q;
    assign act_o[g]                         = act_q;
    assign prio_flat_o[g*PRIO_W +: PRIO_W]  = prio_q;

    // R8: a new request during service leaves the line active-and-pending
    a_r8_repend_while_active: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && edge_hit && !clr_hit && !done_hit) |=> (pend_q && act_q));

    // R7: a taken line drops pending unless re-requested in the same cycle
    a_r7_take_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (take_hit && !edge_hit && !set_hit) |=> !pend_q);
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned PRIO_W    = 4,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        en_i,
  input  logic [NUM_LINES-1:0]        pend_i,
  input  logic [NUM_LINES-1:0]        act_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_flat_i,
  output logic                        win_valid_o,
  output logic [IDX_W-1:0]            win_idx_o,
  output logic [PRIO_W-1:0]           win_prio_o
);

  logic [NUM_LINES-1:0] elig;

  always_comb begin
    elig        = en_i & pend_i & ~act_i;
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_prio_o  = '1;
    // ascending scan with strict compare: equal urgency keeps the lower index
    for (int i = 0; i < NUM_LINES; i++) begin
      if (elig[i] && (!win_valid_o || (prio_flat_i[i*PRIO_W +: PRIO_W] < win_prio_o))) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_prio_o  = prio_flat_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // R3: only an enabled, pending, idle line can win
  a_r3_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (en_i[win_idx_o] && pend_i[win_idx_o] && !act_i[win_idx_o]));

  // R4: a winner exists whenever any line is eligible
  a_r4_no_lost_request: assert property (@(posedge clk) disable iff (!rst_n)
    (|(en_i & pend_i & ~act_i)) |-> win_valid_o);

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [IDX_W-1:0]  push_idx_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [IDX_W-1:0]  top_idx_o,
  output logic [PRIO_W-1:0] top_prio_o
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_mem  [DEPTH];
  logic [PRIO_W-1:0] prio_mem [DEPTH];

  always_comb begin
    cnt_n = cnt_q;
    if (push_i && (cnt_q < CNT_W'(DEPTH))) cnt_n = cnt_q + 1'b1;
    else if (pop_i && (cnt_q != '0))       cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic wr_en;
    assign wr_en = push_i && (cnt_q == CNT_W'(k));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        idx_mem[k]  <= push_idx_i;
        prio_mem[k] <= push_prio_i;
      end
    end
  end

  always_comb begin
    empty_o    = (cnt_q == '0);
    top_idx_o  = '0;
    top_prio_o = '1;
    for (int k = 0; k < DEPTH; k++) begin
      if (cnt_q == CNT_W'(k + 1)) begin
        top_idx_o  = idx_mem[k];
        top_prio_o = prio_mem[k];
      end
    end
  end

  // R7: every pushed handler fits
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CNT_W'(DEPTH)));

  // R9: a pop on an empty stack leaves it empty
  a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> empty_o);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned PRIO_W    = 4,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_op,
  input  logic [IDX_W-1:0]     cfg_line,
  input  logic [PRIO_W-1:0]    cfg_data,
  input  logic                 irq_ack_i,
  input  logic                 irq_done_i,
  output logic                 irq_valid_o,
  output logic [VEC_W-1:0]     irq_vector_o,
  output logic [PRIO_W:0]      run_level_o,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] act_o
);

  localparam int unsigned LVL_W    = PRIO_W + 1;
  localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(1 << PRIO_W);
  localparam int unsigned DEPTH    = NUM_LINES;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [NUM_LINES-1:0]        en_w, pend_w, act_w;
  logic [NUM_LINES*PRIO_W-1:0] prio_flat_w;
  logic                        win_valid;
  logic [IDX_W-1:0]            win_idx;
  logic [PRIO_W-1:0]           win_prio;
  logic                        stk_empty;
  logic [IDX_W-1:0]            top_idx;
  logic [PRIO_W-1:0]           top_prio;
  logic                        take, pop;

  always_comb begin
    run_level_o  = stk_empty ? IDLE_LVL : {1'b0, top_prio};
    irq_valid_o  = win_valid && ({1'b0, win_prio} < run_level_o);
    irq_vector_o = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    take         = irq_ack_i && irq_valid_o && !irq_done_i;
    pop          = irq_done_i && !stk_empty;
  end

  irq_line_bank #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .irq_i(irq_i),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_line(cfg_line), .cfg_data(cfg_data),
    .take_en(take), .take_idx(win_idx), .done_en(pop), .done_idx(top_idx),
    .en_o(en_w), .pend_o(pend_w), .act_o(act_w), .prio_flat_o(prio_flat_w)
  );

  irq_arbiter #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_sync_n),
    .en_i(en_w), .pend_i(pend_w), .act_i(act_w), .prio_flat_i(prio_flat_w),
    .win_valid_o(win_valid), .win_idx_o(win_idx), .win_prio_o(win_prio)
  );

  irq_nest_stack #(
    .DEPTH(DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) u_stack (
    .clk(clk), .rst_n(rst_sync_n),
    .push_i(take), .push_idx_i(win_idx), .push_prio_i(win_prio), .pop_i(pop),
    .empty_o(stk_empty), .top_idx_o(top_idx), .top_prio_o(top_prio)
  );

  assign pend_o = pend_w;
  assign act_o  = act_w;

  // R7: taking a vector marks its line active
  a_r7_take_sets_active: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take |=> act_o[$past(win_idx)]);

  // R7: running level becomes the taken urgency
  a_r7_level_follows_take: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take |=> (run_level_o == {1'b0, $past(win_prio)}));

  // R9: completion clears the finished line
  a_r9_done_clears_active: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pop |=> !act_o[$past(top_idx)]);

  // R10: acknowledge without an offer changes no level
  a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_ack_i && !irq_valid_o && !irq_done_i) |=> $stable(run_level_o));

endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int WD = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [N-1:0] irq;
  logic       cfg_we;
  logic [2:0] cfg_op;
  logic [2:0] cfg_line;
  logic [3:0] cfg_data;
  logic       ack, done;
  logic       valid;
  logic [7:0] vector;
  logic [4:0] run_level;
  logic [N-1:0] pend, act;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_nest_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_line(cfg_line), .cfg_data(cfg_data),
    .irq_ack_i(ack), .irq_done_i(done),
    .irq_valid_o(valid), .irq_vector_o(vector), .run_level_o(run_level),
    .pend_o(pend), .act_o(act)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cfg(input int op, input int line, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_op = 3'(op); cfg_line = 3'(line); cfg_data = 4'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_irq(input int line);
    @(negedge clk); irq[line] = 1'b1;
    @(negedge clk); irq[line] = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", int'(valid), 0);
    check("R1 pend", int'(pend), 0);
    check("R1 act", int'(act), 0);
    check("R1 run_level", int'(run_level), 16);
  endtask

  task automatic t_pending_enable();
    cfg(4, 3, 5);
    pulse_irq(3);
    check("R2 edge sets pending", int'(pend[3]), 1);
    check("R3 disabled not offered", int'(valid), 0);
    cfg(0, 3, 0);
    check("R3 enabled offered", int'(valid), 1);
    check("R5 vector line3", int'(vector), 19);
    cfg(3, 3, 0);
    check("R2 sw clear", int'(pend[3]), 0);
    check("R2 cleared not offered", int'(valid), 0);
    cfg(2, 3, 0);
    check("R2 sw set", int'(pend[3]), 1);
    cfg(3, 3, 0);
    @(negedge clk); irq[3] = 1'b1;
    @(negedge clk);
    cfg(3, 3, 0);
    repeat (3) @(negedge clk);
    check("R2 held level no repend", int'(pend[3]), 0);
    irq[3] = 1'b0;
    cfg(1, 3, 0);
  endtask

  task automatic t_arbitrate();
    cfg(0, 1, 0); cfg(0, 2, 0); cfg(0, 5, 0);
    cfg(4, 1, 7); cfg(4, 2, 3); cfg(4, 5, 3);
    cfg(2, 1, 0); cfg(2, 2, 0); cfg(2, 5, 0);
    check("R4 tie lower index", int'(vector), 18);
    cfg(4, 5, 2);
    check("R4 smaller value wins", int'(vector), 21);
    check("R5 valid for winner", int'(valid), 1);
    cfg(3, 1, 0); cfg(3, 2, 0); cfg(3, 5, 0);
    check("R4 none pending", int'(valid), 0);
  endtask

  task automatic t_nesting();
    cfg(4, 2, 7);
    cfg(2, 1, 0);
    do_ack();
    check("R7 active set", int'(act[1]), 1);
    check("R7 pending cleared", int'(pend[1]), 0);
    check("R7 run level", int'(run_level), 7);
    check("R7 no offer after take", int'(valid), 0);
    cfg(2, 2, 0);
    check("R6 equal level waits", int'(valid), 0);
    cfg(2, 5, 0);
    check("R6 more urgent offered", int'(valid), 1);
    check("R6 vector", int'(vector), 21);
    do_ack();
    check("R7 nested level", int'(run_level), 2);
    check("R7 both active", int'(act), 8'h22);
    do_done();
    check("R9 restore level", int'(run_level), 7);
    check("R9 inner cleared", int'(act), 8'h02);
    check("R9 peer still waits", int'(valid), 0);
    do_done();
    check("R9 idle level", int'(run_level), 16);
    check("R9 peer offered", int'(vector), 18);
    do_ack();
    do_done();
    check("R9 all idle", int'(act), 0);
  endtask

  task automatic t_active_pending();
    cfg(2, 1, 0);
    do_ack();
    cfg(2, 1, 0);
    check("R8 active and pending", int'({pend[1], act[1]}), 3);
    check("R8 not offered", int'(valid), 0);
    do_done();
    check("R8 offered after done", int'(valid), 1);
    check("R8 vector", int'(vector), 17);
    do_ack();
    do_done();
    check("R8 drained", int'(pend | act), 0);
  endtask

  task automatic t_misc();
    do_ack();
    check("R10 stray ack", int'(act), 0);
    check("R10 stray ack level", int'(run_level), 16);
    do_done();
    check("R9 empty done", int'(run_level), 16);
    cfg(2, 1, 0);
    do_ack();
    cfg(4, 1, 1);
    check("R11 level kept", int'(run_level), 7);
    cfg(2, 5, 0);
    @(negedge clk); ack = 1'b1; done = 1'b1;
    @(negedge clk); ack = 1'b0; done = 1'b0;
    check("R10 done wins level", int'(run_level), 16);
    check("R10 ack dropped", int'(act), 0);
    check("R10 still pending", int'(pend[5]), 1);
    do_ack();
    check("R7 taken after", int'(run_level), 2);
    do_done();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; irq = '0; cfg_we = 1'b0; cfg_op = '0; cfg_line = '0;
    cfg_data = '0; ack = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pending_enable();
    t_arbitrate();
    t_nesting();
    t_active_pending();
    t_misc();
    finish_run();
  end
endmodule